// File: doc/BRIEF.md
# Stallable Pipeline Control Shell

This block wraps a fixed-depth compute pipeline with the control needed to run it as one unit of a larger datapath. A caller presents a data word and raises `in_ready`; each such word that is accepted travels through `DEPTH` register stages, and comes out on `result` with `out_ready` high in exactly the cycles that the word is valid. The arithmetic in the stages is a placeholder: each stage adds a small constant, so the whole pipe adds a known bias to every word.

The shell counts accepted inputs and emitted results. Once `ITERS` results have left the pipe, a sticky `done` flag rises and stays high until reset. Words offered after `ITERS` have been accepted are dropped. A caller can pause the pipe with `stall`. The request is registered, so the freeze starts one edge later. While frozen, the stage contents, `out_ready` and `result` hold their values, and `in_ready` is ignored rather than queued.

Top module: `pipe_ctrl_shell`

## Requirements
- R1: A rising edge with `rst` high leaves `out_ready`, `done` and `result` at zero in the following cycle, and the pipe empty, whatever `in_ready`, `stall` and `din` are.
- R2: An edge is frozen exactly when `stall` was sampled high at the previous edge (reset clears this). At an unfrozen edge with `in_ready` high and fewer than `ITERS` words already accepted, `din` is accepted.
- R3: An emitted word equals the accepted `din` plus `DEPTH*(DEPTH+1)/2`, modulo 2^`DATA_W`. `result` is all zeros in any cycle where `out_ready` is low.
- R4: A word accepted at the edge ending cycle t is shown with `out_ready` high in cycle t+`DEPTH` when no frozen edge intervenes. Each word is shown until the next unfrozen edge, so with no freeze it is shown for one cycle.
- R5: `done` rises at the unfrozen edge that ends the showing of the `ITERS`-th result, and stays high until reset.
- R6: Across a frozen edge the pipe contents, `out_ready` and `result` do not change.
- R7: `in_ready` at a frozen edge is ignored and is not held over to a later edge.
- R8: After `ITERS` words have been accepted, further `in_ready` pulses produce no results.
- R9: Results leave the pipe in the order in which their words were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_ready | input | 1 | Qualifies `din` as a valid input word |
| stall | input | 1 | Freeze request, effective from the next edge |
| din | input | DATA_W | Input data word |
| out_ready | output | 1 | High exactly while `result` carries a valid word |
| done | output | 1 | Sticky flag, set after the last result has been shown |
| result | output | DATA_W | Output data word, zero when not valid |

## Verification
The bench builds the shell with `DATA_W`=8, `DEPTH`=3 and `ITERS`=6. The narrow word lets inputs near 255 wrap through the bias of 6. The short iteration limit means a single run reaches `done` and then the input cutoff, and a second run after reset repeats this with stalls placed over the output and over back-to-back inputs. A depth of three keeps several words in flight at once, so a freeze holds a partly filled pipe.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

    // Per-cycle control decisions taken by the shell.
    typedef struct packed {
        logic accept;   // din enters stage 0 at this edge
        logic advance;  // stages shift at this edge
        logic emit;     // the shown result leaves at this edge
    } step_ctl_t;

    // Constant added by stage idx of the placeholder datapath.
    function automatic int stage_bias(input int idx);
        return idx + 1;
    endfunction

    // Total bias added across a pipe of the given depth.
    function automatic int total_bias(input int depth);
        return depth * (depth + 1) / 2;
    endfunction

endpackage

// File: rtl/pipe_stage.sv
module pipe_stage
    import pipe_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [DATA_W-1:0] BIAS = DATA_W'(stage_bias(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else if (advance) begin
            out_vld  <= in_vld;
            out_data <= in_vld ? (in_data + BIAS) : '0;
        end
    end

    // An empty stage carries no stale data downstream.
    assert_empty_stage_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_data == '0));

endmodule

// File: rtl/iter_counter.sv
module iter_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic full
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == TOP);

    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

    assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        full |=> full);

endmodule

// File: rtl/pipe_ctrl_shell.sv
module pipe_ctrl_shell
    import pipe_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int ITERS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_ready,
    input  logic              stall,
    input  logic [DATA_W-1:0] din,
    output logic              out_ready,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    logic      freeze_q;
    logic      in_full;
    logic      out_full;
    step_ctl_t ctl;

    logic [DEPTH:0]             vld_chain;
    logic [DEPTH:0][DATA_W-1:0] dat_chain;

    // Stall request is registered: it freezes the edge after it is seen.
    always_ff @(posedge clk) begin
        if (rst) freeze_q <= 1'b0;
        else     freeze_q <= stall;
    end

    always_comb begin
        ctl.advance = !freeze_q;
        ctl.accept  = in_ready && !freeze_q && !in_full;
        ctl.emit    = out_ready && !freeze_q;
    end

    assign vld_chain[0] = ctl.accept;
    assign dat_chain[0] = din;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        pipe_stage #(
            .DATA_W (DATA_W),
            .IDX    (g)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .advance  (ctl.advance),
            .in_vld   (vld_chain[g]),
            .in_data  (dat_chain[g]),
            .out_vld  (vld_chain[g+1]),
            .out_data (dat_chain[g+1])
        );
    end

    iter_counter #(.LIMIT(ITERS)) u_in_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ctl.accept),
        .full (in_full)
    );

    iter_counter #(.LIMIT(ITERS)) u_out_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ctl.emit),
        .full (out_full)
    );

    assign out_ready = vld_chain[DEPTH];
    assign result    = dat_chain[DEPTH];
    assign done      = out_full;

    // A frozen edge changes nothing visible at the output.
    assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (rst)
        freeze_q |=> ($stable(out_ready) && $stable(result)));

    // A word in the next-to-last stage is shown after an unfrozen edge.
    assert_handoff_R4: assert property (@(posedge clk) disable iff (rst)
        (!freeze_q && vld_chain[DEPTH-1]) |=> out_ready);

    assert_blank_result_R3: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> (result == '0));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // All results out implies all inputs were taken.
    assert_done_after_inputs_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> in_full);

endmodule

// File: tb/pipe_ctrl_shell_test.sv
`timescale 1ns/1ps
module pipe_ctrl_shell_test;
    localparam int DW  = 8;
    localparam int DEP = 3;
    localparam int IT  = 6;
    localparam int SUM = DEP * (DEP + 1) / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_ready = 1'b0;
    logic          stall = 1'b0;
    logic [DW-1:0] din = '0;
    logic          out_ready;
    logic          done;
    logic [DW-1:0] result;

    always #2 clk = ~clk;

    pipe_ctrl_shell #(.DATA_W(DW), .DEPTH(DEP), .ITERS(IT)) uut (
        .clk(clk), .rst(rst), .in_ready(in_ready), .stall(stall), .din(din),
        .out_ready(out_ready), .done(done), .result(result)
    );

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    finished = 0;

    // Behavioural reference: words tagged with the count of unfrozen edges.
    bit m_fz;
    int m_adv, m_in, m_out;
    bit m_done;
    int q_tag[$];
    int q_val[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_fz = 0; m_adv = 0; m_in = 0; m_out = 0; m_done = 0;
            q_tag.delete(); q_val.delete();
        end else begin
            if (!m_fz) begin
                if (q_tag.size() > 0 && q_tag[0] + DEP == m_adv) begin
                    m_out++;
                    if (m_out == IT) m_done = 1;
                    void'(q_tag.pop_front());
                    void'(q_val.pop_front());
                end
                if (in_ready && m_in < IT) begin
                    q_tag.push_back(m_adv);
                    q_val.push_back((int'(din) + SUM) % (1 << DW));
                    m_in++;
                end
                m_adv++;
            end
            m_fz = stall;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            bit exp_v;
            int exp_d;
            exp_v = (q_tag.size() > 0) && (q_tag[0] + DEP == m_adv);
            exp_d = exp_v ? q_val[0] : 0;
            check(tag, "out_ready (R4 R6)", int'(out_ready), int'(exp_v));
            check(tag, "result (R3 R9)", int'(result), exp_d);
            check(tag, "done (R5)", int'(done), int'(m_done));
        end
    end

    task automatic drive(input bit ir, input bit st, input int d);
        @(negedge clk);
        in_ready = ir;
        stall    = st;
        din      = DW'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0);
    endtask

    initial begin
        // R1: reset dominates busy inputs
        tag = "R1";
        in_ready = 1; stall = 1; din = 8'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_ready in reset", int'(out_ready), 0);
        check("R1", "done in reset", int'(done), 0);
        rst = 0; in_ready = 0; stall = 0;

        // R2 R4: single word, latency
        tag = "R2";
        drive(1, 0, 10);
        idle(5);

        // R9 R3: back-to-back words with wraparound
        tag = "R9";
        drive(1, 0, 250);
        drive(1, 0, 251);
        drive(1, 0, 252);
        idle(4);

        // R6 R7: stall arrives with a word; held in_ready while frozen is dropped
        tag = "R6";
        drive(1, 1, 40);
        tag = "R7";
        drive(1, 1, 41);
        drive(1, 1, 41);
        drive(1, 0, 41);
        tag = "R2";
        drive(1, 0, 77);
        idle(1);

        // R8: limit reached, more words ignored
        tag = "R8";
        for (int i = 0; i < 8; i++) drive(1, 0, 99);
        tag = "R5";
        idle(4);
        check("R5", "done after final result", int'(done), 1);
        check("R8", "no result after limit", int'(out_ready), 0);

        // R1: reset clears sticky done
        tag = "R1";
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R1", "done cleared by reset", int'(done), 0);

        // Second run: stalls over back-to-back words and over the output
        tag = "R6";
        drive(1, 0, 1);
        drive(1, 0, 2);
        drive(1, 1, 3);
        drive(0, 1, 0);
        drive(1, 0, 4);
        drive(1, 0, 5);
        drive(0, 0, 0);
        drive(0, 1, 0);
        drive(0, 0, 0);
        drive(1, 0, 6);
        drive(1, 1, 7);
        drive(0, 1, 0);
        drive(0, 1, 0);
        tag = "R5";
        idle(8);
        check("R5", "done in second run", int'(done), 1);
        @(negedge clk);
        check("R5", "done stays high", int'(done), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule